// File: doc/BRIEF.md
# 32-bit Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit load/store core. Each cycle it takes a first operand, a second operand that has already passed through the shifter (along with the shifter's carry-out), a 4-bit operation code and a set-flags request. From these it forms a 32-bit result, a destination write-enable, and the next values of the four condition flags: negative, zero, carry and overflow.

The datapath is combinational. A small flag register holds the current flags. Its carry is the carry input for the with-carry operations, and its overflow bit is kept when a logical operation sets flags. Because of this register, a flag-setting add followed by an add-with-carry chains into a 64-bit sum over two cycles.

The sixteen operations fall into five groups: bitwise logic, add and subtract, reverse subtract, the with-carry variants, and flag-only compare/test forms. The two move forms pass the second operand through either unchanged or inverted.

Top module: `dp_alu_core`

## Requirements
- R1: The op_code values are AND=0x0, EOR=0x1, ORR=0xC, MOV=0xD, BIC=0xE and MVN=0xF. Their results are a&b, a^b, a|b, b, a&~b and ~b, and each asserts res_we.
- R2: The op_code values are SUB=0x2, RSB=0x3 and ADD=0x4. Their results are a-b, b-a and a+b modulo 2^32, and each asserts res_we.
- R3: The op_code values are ADC=0x5, SBC=0x6 and RSC=0x7. Their results are a+b+C, a-b-(1-C) and b-a-(1-C), where C is the registered carry flag.
- R4: Whenever flags are set, N takes bit 31 of res and Z is 1 exactly when res is zero.
- R5: For add forms, C becomes the carry out of bit 31. For subtract forms, C becomes 1 when no borrow occurs.
- R6: For arithmetic forms, V becomes 1 on signed overflow. For example, 0x7FFFFFFF+1 gives 0x80000000 with N=1, Z=0 and V=1.
- R7: For flag-setting logical forms (codes 0x0, 0x1, 0x8, 0x9, 0xC to 0xF), C takes shift_cout and V keeps its previous value.
- R8: The compare/test forms are TST=0x8 (a&b), TEQ=0x9 (a^b), CMP=0xA (a-b) and CMN=0xB (a+b). They drive res with the computed value, update flags, and never assert res_we.
- R9: When set_flags is 0, flags_next equals flags_q, so all four flags hold.
- R10: flags_q is ordered bit3=N, bit2=Z, bit1=C, bit0=V. It clears to 0 on a synchronous reset and loads flags_next on each clock edge. For example, 0xFFFFFFFF+1 with flags set, followed by ADC 0+1, gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_code | input | 4 | Operation code |
| set_flags | input | 1 | Update flags from this operation |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand from the shifter |
| shift_cout | input | 1 | Shifter carry-out, used by logical forms |
| res | output | 32 | Result |
| res_we | output | 1 | Destination write-enable |
| flags_next | output | 4 | Next N,Z,C,V |
| flags_q | output | 4 | Registered N,Z,C,V |

## Verification
A sequence of vectors runs every operation code, with both carry values present for the with-carry forms. The bench checks the result, the write-enable and the flags that follow. A borrowing and a non-borrowing subtract show whether carry means "no borrow" rather than "borrow". A positive overflow and a negative-minus-positive overflow show whether V is computed from the operands that were actually added. Flag-setting logical operations that run after V was set show that V is kept. Repeating the same add with and without set_flags shows that flag updates depend only on that input. The all-ones-plus-one add followed by an add-with-carry shows whether the carry is chained correctly.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  localparam int NUM_FLAGS = 4;
  localparam int FLAG_N    = 3;
  localparam int FLAG_Z    = 2;
  localparam int FLAG_C    = 1;
  localparam int FLAG_V    = 0;

  function automatic logic op_is_arith(input dp_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN:
        return 1'b1;
      default:
        return 1'b0;
    endcase
  endfunction

  // compare/test group: code 10xx
  function automatic logic op_writes_dest(input dp_op_e op);
    return !(op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end

endmodule

// File: rtl/dp_arith_unit.sv
module dp_arith_unit
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   y,
  output logic           cout,
  output logic           ovf
);

  localparam int MSB = W - 1;

  logic          swap_ops;
  logic          invert_second;
  logic          carry_sel;
  logic [W-1:0]  first_in;
  logic [W-1:0]  second_raw;
  logic [W-1:0]  second_in;
  logic [W:0]    sum;

  always_comb begin
    swap_ops      = 1'b0;
    invert_second = 1'b0;
    carry_sel     = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin invert_second = 1'b1; carry_sel = 1'b1; end
      OP_RSB:         begin swap_ops = 1'b1; invert_second = 1'b1; carry_sel = 1'b1; end
      OP_ADC:         carry_sel = cin;
      OP_SBC:         begin invert_second = 1'b1; carry_sel = cin; end
      OP_RSC:         begin swap_ops = 1'b1; invert_second = 1'b1; carry_sel = cin; end
      default:        carry_sel = 1'b0;
    endcase
  end

  assign first_in   = swap_ops ? b : a;
  assign second_raw = swap_ops ? a : b;
  assign second_in  = invert_second ? ~second_raw : second_raw;

  assign sum  = {1'b0, first_in} + {1'b0, second_in} + {{W{1'b0}}, carry_sel};
  assign y    = sum[W-1:0];
  assign cout = sum[W];
  assign ovf  = (first_in[MSB] == second_in[MSB]) && (sum[MSB] != first_in[MSB]);

endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] d,
  output logic [NF-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           op_code,
  input  logic                 set_flags,
  input  logic [W-1:0]         op_a,
  input  logic [W-1:0]         op_b,
  input  logic                 shift_cout,
  output logic [W-1:0]         res,
  output logic                 res_we,
  output logic [NUM_FLAGS-1:0] flags_next,
  output logic [NUM_FLAGS-1:0] flags_q
);

  dp_op_e        op_e;
  logic [W-1:0]  logic_y;
  logic [W-1:0]  arith_y;
  logic          arith_c;
  logic          arith_v;
  logic          is_arith;
  logic          new_c;
  logic          new_v;

  assign op_e     = dp_op_e'(op_code);
  assign is_arith = op_is_arith(op_e);

  dp_logic_unit #(.W(W)) u_logic (
    .op (op_e),
    .a  (op_a),
    .b  (op_b),
    .y  (logic_y)
  );

  dp_arith_unit #(.W(W)) u_arith (
    .op   (op_e),
    .a    (op_a),
    .b    (op_b),
    .cin  (flags_q[FLAG_C]),
    .y    (arith_y),
    .cout (arith_c),
    .ovf  (arith_v)
  );

  assign res    = is_arith ? arith_y : logic_y;
  assign res_we = op_writes_dest(op_e);

  assign new_c = is_arith ? arith_c : shift_cout;
  assign new_v = is_arith ? arith_v : flags_q[FLAG_V];

  always_comb begin
    flags_next = flags_q;
    if (set_flags) begin
      flags_next[FLAG_N] = res[W-1];
      flags_next[FLAG_Z] = (res == '0);
      flags_next[FLAG_C] = new_c;
      flags_next[FLAG_V] = new_v;
    end
  end

  dp_flag_reg #(.NF(NUM_FLAGS)) u_flags (
    .clk (clk),
    .rst (rst),
    .d   (flags_next),
    .q   (flags_q)
  );

endmodule

// File: rtl/dp_alu_checks.sv
module dp_alu_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_code,
  input logic         set_flags,
  input logic [W-1:0] res,
  input logic         res_we,
  input logic [3:0]   flags_q
);

  logic is_logical;
  assign is_logical = (op_code inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF});

  // R8
  a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_code[3:2] == 2'b10) |-> !res_we);

  // R1
  a_r1_write: assert property (@(posedge clk) disable iff (rst)
    (op_code[3:2] != 2'b10) |-> res_we);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> (flags_q == $past(flags_q)));

  // R4
  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flags_q[2] == ($past(res) == '0)));

  // R4
  a_r4_neg: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flags_q[3] == $past(res[W-1])));

  // R7
  a_r7_logic_v: assert property (@(posedge clk) disable iff (rst)
    (set_flags && is_logical) |=> (flags_q[0] == $past(flags_q[0])));

endmodule

bind dp_alu_core dp_alu_checks #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_code   (op_code),
  .set_flags (set_flags),
  .res       (res),
  .res_we    (res_we),
  .flags_q   (flags_q)
);

// File: tb/sim_dp_alu_core.sv
module sim_dp_alu_core;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic        sf;
    logic [31:0] a;
    logic [31:0] b;
    logic        sc;
    logic [31:0] r;
    logic        we;
    logic [3:0]  f;
  } vec_t;

  // flags f: bit3 N, bit2 Z, bit1 C, bit0 V (after the clock edge)
  localparam vec_t VEC [NV] = '{
    '{4'd10, 4'h4, 1'b1, 32'hFFFFFFFF, 32'h1, 1'b0, 32'h0,        1'b1, 4'h6}, // R10 low word
    '{4'd10, 4'h5, 1'b1, 32'h0,        32'h1, 1'b0, 32'h2,        1'b1, 4'h0}, // R10 high word
    '{4'd6,  4'h4, 1'b1, 32'h7FFFFFFF, 32'h1, 1'b0, 32'h80000000, 1'b1, 4'h9}, // R6
    '{4'd7,  4'h0, 1'b1, 32'h3,        32'h1E,1'b1, 32'h2,        1'b1, 4'h3}, // R7 AND keeps V
    '{4'd9,  4'h1, 1'b0, 32'h3,        32'h1E,1'b0, 32'h1D,       1'b1, 4'h3}, // R9 EOR no flags
    '{4'd5,  4'h2, 1'b1, 32'h5,        32'h5, 1'b0, 32'h0,        1'b1, 4'h6}, // R5 SUB no borrow
    '{4'd3,  4'h6, 1'b1, 32'hA,        32'h3, 1'b0, 32'h7,        1'b1, 4'h2}, // R3 SBC C=1
    '{4'd5,  4'h2, 1'b1, 32'h3,        32'h5, 1'b0, 32'hFFFFFFFE, 1'b1, 4'h8}, // R5 SUB borrow
    '{4'd3,  4'h6, 1'b1, 32'hA,        32'h3, 1'b0, 32'h6,        1'b1, 4'h2}, // R3 SBC C=0
    '{4'd2,  4'h3, 1'b1, 32'h1,        32'h4, 1'b0, 32'h3,        1'b1, 4'h2}, // R2 RSB
    '{4'd8,  4'hA, 1'b1, 32'h0,        32'h1, 1'b0, 32'hFFFFFFFF, 1'b0, 4'h8}, // R8 CMP
    '{4'd3,  4'h7, 1'b1, 32'h1,        32'h4, 1'b0, 32'h2,        1'b1, 4'h2}, // R3 RSC C=0
    '{4'd8,  4'hB, 1'b1, 32'hFFFFFFFF, 32'h1, 1'b0, 32'h0,        1'b0, 4'h6}, // R8 CMN
    '{4'd8,  4'h8, 1'b1, 32'hF0,       32'hF, 1'b0, 32'h0,        1'b0, 4'h4}, // R8 TST
    '{4'd8,  4'h9, 1'b1, 32'h80000000, 32'h0, 1'b1, 32'h80000000, 1'b0, 4'hA}, // R8 TEQ
    '{4'd1,  4'hC, 1'b0, 32'hF0,       32'hF, 1'b0, 32'hFF,       1'b1, 4'hA}, // R1 ORR
    '{4'd1,  4'hD, 1'b1, 32'h1234,     32'h0, 1'b0, 32'h0,        1'b1, 4'h4}, // R1 MOV
    '{4'd1,  4'hE, 1'b1, 32'hFF,       32'hF, 1'b1, 32'hF0,       1'b1, 4'h2}, // R1 BIC
    '{4'd1,  4'hF, 1'b1, 32'h0,        32'h0, 1'b0, 32'hFFFFFFFF, 1'b1, 4'h8}, // R1 MVN
    '{4'd9,  4'h4, 1'b0, 32'h7FFFFFFF, 32'h1, 1'b0, 32'h80000000, 1'b1, 4'h8}, // R9 ADD no flags
    '{4'd6,  4'h4, 1'b1, 32'h7FFFFFFF, 32'h1, 1'b0, 32'h80000000, 1'b1, 4'h9}, // R6 again
    '{4'd6,  4'hA, 1'b1, 32'h80000000, 32'h1, 1'b0, 32'h7FFFFFFF, 1'b0, 4'h3}, // R6 CMP overflow
    '{4'd3,  4'h5, 1'b1, 32'h40000000, 32'h5, 1'b0, 32'h40000006, 1'b1, 4'h0}  // R3 ADC C=1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = 4'h0;
  logic        set_flags = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        shift_cout = 1'b0;
  logic [31:0] res;
  logic        res_we;
  logic [3:0]  flags_next;
  logic [3:0]  flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu_core #(.W(32)) u0 (
    .clk (clk), .rst (rst), .op_code (op_code), .set_flags (set_flags),
    .op_a (op_a), .op_b (op_b), .shift_cout (shift_cout),
    .res (res), .res_we (res_we), .flags_next (flags_next), .flags_q (flags_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic sf, input logic [31:0] a,
                       input logic [31:0] b, input logic sc);
    @(negedge clk);
    op_code = op; set_flags = sf; op_a = a; op_b = b; shift_cout = sc;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10 reset flags", {28'h0, flags_q}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].sf, VEC[i].a, VEC[i].b, VEC[i].sc);
      check($sformatf("R%0d vec %0d res", VEC[i].req, i), res, VEC[i].r);
      check($sformatf("R%0d vec %0d res_we", VEC[i].req, i), {31'h0, res_we}, {31'h0, VEC[i].we});
      @(posedge clk);
      #(CLK_PERIOD/4);
      check($sformatf("R%0d vec %0d flags", VEC[i].req, i), {28'h0, flags_q}, {28'h0, VEC[i].f});
    end

    // R9: set_flags low, flags_next mirrors flags_q (currently 0)
    apply(4'h2, 1'b0, 32'h0, 32'h1, 1'b1);
    check("R9 flags_next hold", {28'h0, flags_next}, {28'h0, flags_q});

    // R10: reset clears a nonzero flag state
    apply(4'h4, 1'b1, 32'hFFFFFFFF, 32'h1, 1'b0);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10 flags before reset", {28'h0, flags_q}, 32'h6);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10 flags after reset", {28'h0, flags_q}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    set_flags = 1'b0;

    // R2 plain ADD/SUB without flags
    apply(4'h4, 1'b0, 32'h10, 32'h20, 1'b0);
    check("R2 ADD", res, 32'h30);
    apply(4'h2, 1'b0, 32'h10, 32'h20, 1'b0);
    check("R2 SUB wrap", res, 32'hFFFFFFF0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule